// File: doc/BRIEF.md
# Doorbell Mailbox Register Bank with Serial Host Port

This block is a byte-wide register bank shared by two agents. An external host reaches it through a serial slave port that uses clock mode 3. A local processor reaches it through a synchronous register port with an interrupt line. Messages pass through doorbell mailboxes in both directions. A write to a mailbox sets a status bit that the other side clears by reading that mailbox. A scratch area gives plain byte storage with no side effects. The host can also request a reset of the local processor.

The serial logic is clocked only by the serial clock, and that clock runs only while chip select is low. Every host-side update therefore completes on the last edge of its own frame. Every event that crosses to the local clock is a toggle, and the local side picks it up through a two-flop synchronizer and an edge detector. Quasi-static byte values cross through two-flop synchronizers. The local port accepts a read or write in every cycle and never pushes back. Read data arrives one cycle later together with a valid strobe, and the consumer must take it in that cycle.

Top module: `spi_mbox_bank`

## Requirements
- R1: A frame is 16 serial clock edges with chip select low. The sampling edge is rising, and MISO changes on falling edges. The first byte is a command: bit 7 is 1 for a read and 0 for a write, and bits 6:0 are the address. The second byte is the write data, or the read data driven MSB-first on MISO. A write takes effect only on the 16th rising edge, so a frame with fewer edges changes nothing.
- R2: Inbound mailboxes sit at 05h to 08h. The host writes them, and a local read of the same address returns the byte.
- R3: A host write to inbound mailbox n sets bit n (bits 3:0) of the control/status byte at 00h. Both sides can read that bit.
- R4: Bits 7:4 of 00h are enables. Bit 4 gates mailbox 0 and bits 7:5 gate mailboxes 3 to 1. A host write to 00h changes only bits 7:4. loc_irq is high exactly when some status bit and its enable are both set.
- R5: A local read of inbound mailbox n clears status bit n and no other bit.
- R6: Outbound mailboxes sit at 0Fh upward, one per NUM_HMB. A local write stores the byte and sets bit n of the outbound status byte at 01h. The host reads the byte back at the same address.
- R7: host_irq is high while any outbound status bit is set. A host read of outbound mailbox n clears bit n.
- R8: Scratch bytes sit at 0Ah to 0Dh. The host writes them, and both sides read them. They set no status bit and raise no interrupt.
- R9: A host write of 1 in bit 0 of 19h drives cpu_reset_req high for exactly RST_STRETCH local cycles. Writing 0 in bit 0 has no effect, and 19h reads as 0.
- R10: After reset, all storage, status and enables are zero, and loc_irq, host_irq, cpu_reset_req, loc_rvalid and spi_miso are low.
- R11: A local read raises loc_rvalid, with data, in the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset for both sides |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_addr | input | 7 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data |
| loc_rvalid | output | 1 | loc_rdata valid |
| loc_irq | output | 1 | Interrupt to local processor |
| host_irq | output | 1 | Interrupt to host |
| cpu_reset_req | output | 1 | Stretched reset request for the local processor |

## Verification
Wrong status or enable state appears on loc_irq or host_irq. A reference model compares both pins on every local clock once the crossing has settled, so such a fault shows within one settle window. A lost or stuck toggle shows up the same way, or as a wrong byte at 00h or 01h on the next read by either side. Errors in the serial shifter show as a corrupted byte in the very next host read. A partial frame that wrongly commits shows as a status bit set where none should be.

// File: rtl/spi_mbox_pkg.sv
package spi_mbox_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int FRAME_BITS = 16;
  localparam int NUM_LMB    = 4;

  localparam logic [ADDR_W-1:0] A_LCTL  = 7'h00;
  localparam logic [ADDR_W-1:0] A_HSTAT = 7'h01;
  localparam logic [ADDR_W-1:0] A_LMB0  = 7'h05;
  localparam logic [ADDR_W-1:0] A_SCR0  = 7'h0A;
  localparam logic [ADDR_W-1:0] A_HMB0  = 7'h0F;
  localparam logic [ADDR_W-1:0] A_RSTC  = 7'h19;
endpackage

// File: rtl/mbx_sync_vec.sv
module mbx_sync_vec #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbx_toggle_rx.sv
module mbx_toggle_rx #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tgl_in,
  output logic [W-1:0] pulse
);
  logic [W-1:0] tgl_s;
  logic [W-1:0] tgl_prev;

  mbx_sync_vec #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tgl_in),
    .q     (tgl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_prev <= '0;
    else        tgl_prev <= tgl_s;
  end

  assign pulse = tgl_s ^ tgl_prev;
endmodule

// File: rtl/mbx_spi_side.sv
module mbx_spi_side
  import spi_mbox_pkg::*;
#(
  parameter int NUM_HMB = 4,
  parameter int NUM_SCR = 4
) (
  input  logic                               rst_n,
  input  logic                               spi_sck,
  input  logic                               spi_cs_n,
  input  logic                               spi_mosi,
  output logic                               spi_miso,
  input  logic [NUM_LMB-1:0]                 lstat_a,
  input  logic [NUM_HMB-1:0]                 hstat_a,
  input  logic [NUM_HMB-1:0][BYTE_W-1:0]     hmb_a,
  output logic [NUM_LMB-1:0][BYTE_W-1:0]     lmb_q,
  output logic [NUM_SCR-1:0][BYTE_W-1:0]     scr_q,
  output logic [NUM_LMB-1:0]                 en_q,
  output logic [NUM_LMB-1:0]                 lmb_wr_tgl,
  output logic [NUM_HMB-1:0]                 hmb_rd_tgl,
  output logic                               rst_tgl
);
  localparam int CNT_W  = $clog2(FRAME_BITS + 1);
  localparam int SR_W   = FRAME_BITS - 1;
  localparam int SYNC_W = NUM_LMB + NUM_HMB + NUM_HMB * BYTE_W;

  logic [CNT_W-1:0]  bit_cnt;
  logic [SR_W-1:0]   in_sr;
  logic [BYTE_W-1:0] out_sr;
  logic [BYTE_W-1:0] rd_val;
  logic              last_edge;
  logic              wr_commit;
  logic              rd_commit;
  logic [ADDR_W-1:0] fr_addr;
  logic [BYTE_W-1:0] fr_data;
  logic [ADDR_W-1:0] cmd_addr;

  logic [NUM_LMB-1:0]             lstat_s;
  logic [NUM_HMB-1:0]             hstat_s;
  logic [NUM_HMB-1:0][BYTE_W-1:0] hmb_s;
  logic [SYNC_W-1:0]              sync_q;

  mbx_sync_vec #(.W(SYNC_W)) u_sync_in (
    .clk   (spi_sck),
    .rst_n (rst_n),
    .d     ({lstat_a, hstat_a, hmb_a}),
    .q     (sync_q)
  );
  assign {lstat_s, hstat_s, hmb_s} = sync_q;

  // Frame counter and input shifter, cleared whenever select is released
  always_ff @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      bit_cnt <= '0;
      in_sr   <= '0;
    end else begin
      if (bit_cnt != CNT_W'(FRAME_BITS)) bit_cnt <= bit_cnt + 1'b1;
      in_sr <= {in_sr[SR_W-2:0], spi_mosi};
    end
  end

  assign last_edge = (bit_cnt == CNT_W'(FRAME_BITS - 1));
  assign wr_commit = last_edge && !in_sr[SR_W-1];
  assign rd_commit = last_edge &&  in_sr[SR_W-1];
  assign fr_addr   = in_sr[SR_W-2 -: ADDR_W];
  assign fr_data   = {in_sr[BYTE_W-2:0], spi_mosi};
  assign cmd_addr  = in_sr[ADDR_W-1:0];

  // Host-owned storage and event toggles, all committed on the final edge
  always_ff @(posedge spi_sck or negedge rst_n) begin
    if (!rst_n) begin
      lmb_q      <= '0;
      scr_q      <= '0;
      en_q       <= '0;
      lmb_wr_tgl <= '0;
      hmb_rd_tgl <= '0;
      rst_tgl    <= 1'b0;
    end else begin
      if (wr_commit) begin
        if (fr_addr == A_LCTL) en_q <= fr_data[BYTE_W-1 -: NUM_LMB];
        if (fr_addr == A_RSTC && fr_data[0]) rst_tgl <= ~rst_tgl;
        for (int i = 0; i < NUM_LMB; i++) begin
          if (fr_addr == A_LMB0 + ADDR_W'(i)) begin
            lmb_q[i]      <= fr_data;
            lmb_wr_tgl[i] <= ~lmb_wr_tgl[i];
          end
        end
        for (int i = 0; i < NUM_SCR; i++) begin
          if (fr_addr == A_SCR0 + ADDR_W'(i)) scr_q[i] <= fr_data;
        end
      end
      if (rd_commit) begin
        for (int i = 0; i < NUM_HMB; i++) begin
          if (fr_addr == A_HMB0 + ADDR_W'(i)) hmb_rd_tgl[i] <= ~hmb_rd_tgl[i];
        end
      end
    end
  end

  // Host read mux, evaluated once the command byte is complete
  always_comb begin
    rd_val = '0;
    if (cmd_addr == A_LCTL)  rd_val = {en_q, lstat_s};
    if (cmd_addr == A_HSTAT) rd_val = BYTE_W'(hstat_s);
    for (int i = 0; i < NUM_LMB; i++)
      if (cmd_addr == A_LMB0 + ADDR_W'(i)) rd_val = lmb_q[i];
    for (int i = 0; i < NUM_SCR; i++)
      if (cmd_addr == A_SCR0 + ADDR_W'(i)) rd_val = scr_q[i];
    for (int i = 0; i < NUM_HMB; i++)
      if (cmd_addr == A_HMB0 + ADDR_W'(i)) rd_val = hmb_s[i];
  end

  // Output shifter on falling edges: load after the command, then shift
  always_ff @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n)                          out_sr <= '0;
    else if (bit_cnt == CNT_W'(BYTE_W))    out_sr <= in_sr[BYTE_W-1] ? rd_val : '0;
    else                                   out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
  end

  assign spi_miso = out_sr[BYTE_W-1];

  AST_COMMIT_AT_FRAME_END: assert property (@(posedge spi_sck) disable iff (!rst_n || spi_cs_n)
    (bit_cnt != CNT_W'(FRAME_BITS - 1)) |=> $stable({lmb_wr_tgl, hmb_rd_tgl, rst_tgl})); // R1
endmodule

// File: rtl/mbx_local_side.sv
module mbx_local_side
  import spi_mbox_pkg::*;
#(
  parameter int NUM_HMB     = 4,
  parameter int NUM_SCR     = 4,
  parameter int RST_STRETCH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           loc_rd,
  input  logic                           loc_wr,
  input  logic [ADDR_W-1:0]              loc_addr,
  input  logic [BYTE_W-1:0]              loc_wdata,
  output logic [BYTE_W-1:0]              loc_rdata,
  output logic                           loc_rvalid,
  output logic                           loc_irq,
  output logic                           host_irq,
  output logic                           cpu_reset_req,
  input  logic [NUM_LMB-1:0][BYTE_W-1:0] lmb_a,
  input  logic [NUM_SCR-1:0][BYTE_W-1:0] scr_a,
  input  logic [NUM_LMB-1:0]             en_a,
  input  logic [NUM_LMB-1:0]             lmb_wr_tgl,
  input  logic [NUM_HMB-1:0]             hmb_rd_tgl,
  input  logic                           rst_tgl,
  output logic [NUM_LMB-1:0]             lstat,
  output logic [NUM_HMB-1:0]             hstat,
  output logic [NUM_HMB-1:0][BYTE_W-1:0] hmb_q
);
  localparam int EV_W   = NUM_LMB + NUM_HMB + 1;
  localparam int DAT_W  = NUM_LMB * BYTE_W + NUM_SCR * BYTE_W + NUM_LMB;
  localparam int RC_W   = $clog2(RST_STRETCH + 1);
  localparam int HC_W   = RC_W + 1;

  logic [EV_W-1:0]                ev_pulse;
  logic [NUM_LMB-1:0]             lmb_wr_p;
  logic [NUM_HMB-1:0]             hmb_rd_p;
  logic                           rst_p;
  logic [DAT_W-1:0]               dat_q;
  logic [NUM_LMB-1:0][BYTE_W-1:0] lmb_s;
  logic [NUM_SCR-1:0][BYTE_W-1:0] scr_s;
  logic [NUM_LMB-1:0]             en_s;
  logic [NUM_LMB-1:0]             lclr;
  logic [NUM_HMB-1:0]             hset;
  logic [BYTE_W-1:0]              rd_mux;
  logic [RC_W-1:0]                rst_cnt;
  logic [HC_W-1:0]                hi_cnt;

  mbx_toggle_rx #(.W(EV_W)) u_ev (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl_in ({lmb_wr_tgl, hmb_rd_tgl, rst_tgl}),
    .pulse  (ev_pulse)
  );
  assign {lmb_wr_p, hmb_rd_p, rst_p} = ev_pulse;

  mbx_sync_vec #(.W(DAT_W)) u_dat (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({lmb_a, scr_a, en_a}),
    .q     (dat_q)
  );
  assign {lmb_s, scr_s, en_s} = dat_q;

  always_comb begin
    for (int i = 0; i < NUM_LMB; i++) lclr[i] = loc_rd && (loc_addr == A_LMB0 + ADDR_W'(i));
    for (int i = 0; i < NUM_HMB; i++) hset[i] = loc_wr && (loc_addr == A_HMB0 + ADDR_W'(i));
  end

  // Status: a new event in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lstat <= '0;
      hstat <= '0;
      hmb_q <= '0;
    end else begin
      lstat <= (lstat & ~lclr) | lmb_wr_p;
      hstat <= (hstat & ~hmb_rd_p) | hset;
      for (int i = 0; i < NUM_HMB; i++)
        if (hset[i]) hmb_q[i] <= loc_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (loc_addr == A_LCTL)  rd_mux = {en_s, lstat};
    if (loc_addr == A_HSTAT) rd_mux = BYTE_W'(hstat);
    for (int i = 0; i < NUM_LMB; i++)
      if (loc_addr == A_LMB0 + ADDR_W'(i)) rd_mux = lmb_s[i];
    for (int i = 0; i < NUM_SCR; i++)
      if (loc_addr == A_SCR0 + ADDR_W'(i)) rd_mux = scr_s[i];
    for (int i = 0; i < NUM_HMB; i++)
      if (loc_addr == A_HMB0 + ADDR_W'(i)) rd_mux = hmb_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_rdata  <= '0;
      loc_rvalid <= 1'b0;
    end else begin
      loc_rvalid <= loc_rd;
      if (loc_rd) loc_rdata <= rd_mux;
    end
  end

  // Reset request stretcher
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rst_cnt <= '0;
    else if (rst_p)           rst_cnt <= RC_W'(RST_STRETCH);
    else if (rst_cnt != '0)   rst_cnt <= rst_cnt - 1'b1;
  end

  assign cpu_reset_req = (rst_cnt != '0);
  assign loc_irq       = |(lstat & en_s);
  assign host_irq      = |hstat;

  // Width counter used only by the pulse-width assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              hi_cnt <= '0;
    else if (!cpu_reset_req)                 hi_cnt <= '0;
    else if (hi_cnt != {HC_W{1'b1}})         hi_cnt <= hi_cnt + 1'b1;
  end

  AST_RESET_REQ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset_req) |-> (hi_cnt >= HC_W'(RST_STRETCH))); // R9

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rd |=> loc_rvalid); // R11

  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_rd |=> !loc_rvalid); // R11

  for (genvar g = 0; g < NUM_LMB; g++) begin : g_lmb_chk
    AST_LSTAT_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_rd && loc_addr == A_LMB0 + ADDR_W'(g) && !lmb_wr_p[g]) |=> !lstat[g]); // R5
  end

  for (genvar g = 0; g < NUM_HMB; g++) begin : g_hmb_chk
    AST_HSTAT_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_wr && loc_addr == A_HMB0 + ADDR_W'(g)) |=> (hstat[g] && host_irq)); // R6
  end
endmodule

// File: rtl/spi_mbox_bank.sv
module spi_mbox_bank
  import spi_mbox_pkg::*;
#(
  parameter int NUM_HMB     = 4,
  parameter int NUM_SCR     = 4,
  parameter int RST_STRETCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              loc_rd,
  input  logic              loc_wr,
  input  logic [6:0]        loc_addr,
  input  logic [7:0]        loc_wdata,
  output logic [7:0]        loc_rdata,
  output logic              loc_rvalid,
  output logic              loc_irq,
  output logic              host_irq,
  output logic              cpu_reset_req
);
  logic [NUM_LMB-1:0][BYTE_W-1:0] lmb_q;
  logic [NUM_SCR-1:0][BYTE_W-1:0] scr_q;
  logic [NUM_LMB-1:0]             en_q;
  logic [NUM_LMB-1:0]             lmb_wr_tgl;
  logic [NUM_HMB-1:0]             hmb_rd_tgl;
  logic                           rst_tgl;
  logic [NUM_LMB-1:0]             lstat;
  logic [NUM_HMB-1:0]             hstat;
  logic [NUM_HMB-1:0][BYTE_W-1:0] hmb_q;

  mbx_spi_side #(.NUM_HMB(NUM_HMB), .NUM_SCR(NUM_SCR)) u_spi (
    .rst_n      (rst_n),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .lstat_a    (lstat),
    .hstat_a    (hstat),
    .hmb_a      (hmb_q),
    .lmb_q      (lmb_q),
    .scr_q      (scr_q),
    .en_q       (en_q),
    .lmb_wr_tgl (lmb_wr_tgl),
    .hmb_rd_tgl (hmb_rd_tgl),
    .rst_tgl    (rst_tgl)
  );

  mbx_local_side #(.NUM_HMB(NUM_HMB), .NUM_SCR(NUM_SCR), .RST_STRETCH(RST_STRETCH)) u_loc (
    .clk           (clk),
    .rst_n         (rst_n),
    .loc_rd        (loc_rd),
    .loc_wr        (loc_wr),
    .loc_addr      (loc_addr),
    .loc_wdata     (loc_wdata),
    .loc_rdata     (loc_rdata),
    .loc_rvalid    (loc_rvalid),
    .loc_irq       (loc_irq),
    .host_irq      (host_irq),
    .cpu_reset_req (cpu_reset_req),
    .lmb_a         (lmb_q),
    .scr_a         (scr_q),
    .en_a          (en_q),
    .lmb_wr_tgl    (lmb_wr_tgl),
    .hmb_rd_tgl    (hmb_rd_tgl),
    .rst_tgl       (rst_tgl),
    .lstat         (lstat),
    .hstat         (hstat),
    .hmb_q         (hmb_q)
  );
endmodule

// File: tb/spi_mbox_bank_tb_top.sv
module spi_mbox_bank_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int SCK_HALF    = 13;
  localparam int SETTLE      = 12;
  localparam int RST_STRETCH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       loc_rd = 1'b0;
  logic       loc_wr = 1'b0;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  logic       loc_rvalid;
  logic       loc_irq;
  logic       host_irq;
  logic       cpu_reset_req;

  int checks = 0;
  int errors = 0;
  bit quiet  = 1'b0;
  int rst_hi = 0;

  logic [7:0] m_lmb [4];
  logic [7:0] m_scr [4];
  logic [7:0] m_hmb [4];
  logic [3:0] m_lstat = '0;
  logic [3:0] m_en    = '0;
  logic [3:0] m_hstat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mbox_bank #(.NUM_HMB(4), .NUM_SCR(4), .RST_STRETCH(RST_STRETCH)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sck       (spi_sck),
    .spi_cs_n      (spi_cs_n),
    .spi_mosi      (spi_mosi),
    .spi_miso      (spi_miso),
    .loc_rd        (loc_rd),
    .loc_wr        (loc_wr),
    .loc_addr      (loc_addr),
    .loc_wdata     (loc_wdata),
    .loc_rdata     (loc_rdata),
    .loc_rvalid    (loc_rvalid),
    .loc_irq       (loc_irq),
    .host_irq      (host_irq),
    .cpu_reset_req (cpu_reset_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    if (a == 7'h00) return {m_en, m_lstat};
    if (a == 7'h01) return {4'b0, m_hstat};
    if (a >= 7'h05 && a <= 7'h08) return m_lmb[a - 7'h05];
    if (a >= 7'h0A && a <= 7'h0D) return m_scr[a - 7'h0A];
    if (a >= 7'h0F && a <= 7'h12) return m_hmb[a - 7'h0F];
    return 8'h00;
  endfunction

  // Per-clock comparison of the interrupt and reset pins against the model
  always @(posedge clk) if (cpu_reset_req) rst_hi++;
  always @(negedge clk) begin
    if (quiet && rst_n) begin
      chk("R4 loc_irq", {7'b0, loc_irq}, {7'b0, |(m_lstat & m_en)});
      chk("R7 host_irq", {7'b0, host_irq}, {7'b0, |m_hstat});
      chk("R9 reset idle", {7'b0, cpu_reset_req}, 8'h00);
    end
  end

  task automatic spi_xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                          output logic [7:0] rd);
    rd = '0;
    quiet = 1'b0;
    spi_cs_n = 1'b0;
    #SCK_HALF;
    for (int b = 0; b < nbits; b++) begin
      spi_sck = 1'b0;
      spi_mosi = (b < 8) ? cmd[7-b] : wd[15-b];
      #SCK_HALF;
      if (b >= 8) rd[15-b] = spi_miso;
      spi_sck = 1'b1;
      #SCK_HALF;
    end
    spi_cs_n = 1'b1;
    #SCK_HALF;
    repeat (SETTLE) @(posedge clk);
  endtask

  task automatic settle_done();
    @(negedge clk);
    quiet = 1'b1;
  endtask

  task automatic host_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    spi_xfer({1'b0, a}, d, 16, dummy);
    if (a == 7'h00) m_en = d[7:4];
    if (a >= 7'h05 && a <= 7'h08) begin m_lmb[a-7'h05] = d; m_lstat[a-7'h05] = 1'b1; end
    if (a >= 7'h0A && a <= 7'h0D) m_scr[a-7'h0A] = d;
    settle_done();
  endtask

  task automatic host_read(input string req, input logic [6:0] a);
    logic [7:0] got;
    logic [7:0] exp;
    exp = exp_rd(a);
    spi_xfer({1'b1, a}, 8'h00, 16, got);
    chk(req, got, exp);
    if (a >= 7'h0F && a <= 7'h12) m_hstat[a-7'h0F] = 1'b0;
    settle_done();
  endtask

  task automatic loc_read(input string req, input logic [6:0] a);
    logic [7:0] exp;
    @(negedge clk);
    exp = exp_rd(a);
    loc_rd = 1'b1; loc_addr = a;
    @(posedge clk);
    if (a >= 7'h05 && a <= 7'h08) m_lstat[a-7'h05] = 1'b0;
    @(negedge clk);
    loc_rd = 1'b0;
    chk("R11 rvalid after read", {7'b0, loc_rvalid}, 8'h01);
    chk(req, loc_rdata, exp);
  endtask

  task automatic loc_write(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
    @(posedge clk);
    if (a >= 7'h0F && a <= 7'h12) begin m_hmb[a-7'h0F] = d; m_hstat[a-7'h0F] = 1'b1; end
    @(negedge clk);
    loc_wr = 1'b0;
    chk("R11 no rvalid after write", {7'b0, loc_rvalid}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] dummy;
    for (int i = 0; i < 4; i++) begin m_lmb[i] = '0; m_scr[i] = '0; m_hmb[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 loc_irq reset", {7'b0, loc_irq}, 8'h00);
    chk("R10 host_irq reset", {7'b0, host_irq}, 8'h00);
    chk("R10 reset_req reset", {7'b0, cpu_reset_req}, 8'h00);
    chk("R10 rvalid reset", {7'b0, loc_rvalid}, 8'h00);
    chk("R10 miso reset", {7'b0, spi_miso}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    quiet = 1'b1;

    host_read("R10 ctl zero", 7'h00);
    // R2 R3: doorbell into mailbox 1
    host_write(7'h06, 8'hA5);
    host_read("R3 host sees status", 7'h00);
    loc_read("R3 local sees status", 7'h00);
    // R4: low nibble ignored, enable mailbox 1 only
    host_write(7'h00, 8'h2F);
    host_read("R4 enables and status", 7'h00);
    // R2 R5: read clears and drops interrupt
    loc_read("R2 mailbox data", 7'h06);
    loc_read("R5 status cleared", 7'h00);
    // R4 gating and R5 selective clear
    host_write(7'h05, 8'h3C);
    host_write(7'h08, 8'hC3);
    host_write(7'h00, 8'h10);
    loc_read("R2 mailbox 3 data", 7'h08);
    loc_read("R5 only bit 3 cleared", 7'h00);
    // R8 scratch
    host_write(7'h0A, 8'h11);
    host_write(7'h0D, 8'hDD);
    host_read("R8 host scratch readback", 7'h0D);
    loc_read("R8 local scratch read", 7'h0A);
    loc_read("R8 no status change", 7'h00);
    // R6 R7 outbound doorbells
    loc_write(7'h0F, 8'h5A);
    loc_write(7'h11, 8'h77);
    loc_read("R6 local sees out status", 7'h01);
    host_read("R6 host sees out status", 7'h01);
    host_read("R6 host reads mailbox 0", 7'h0F);
    host_read("R7 bit 0 cleared", 7'h01);
    host_read("R6 host reads mailbox 2", 7'h11);
    host_read("R7 all cleared", 7'h01);
    // R1 truncated frame commits nothing
    spi_xfer({1'b0, 7'h07}, 8'h99, 12, dummy);
    settle_done();
    host_read("R1 partial frame no status", 7'h00);
    host_read("R1 partial frame no data", 7'h07);
    loc_read("R2 mailbox 0 data", 7'h05);
    // R9 reset request
    rst_hi = 0;
    host_write(7'h19, 8'hFE);
    chk("R9 bit0 clear no request", rst_hi[7:0], 8'h00);
    rst_hi = 0;
    host_write(7'h19, 8'h01);
    chk("R9 stretched width", rst_hi[7:0], 8'(RST_STRETCH));
    host_read("R9 reads zero", 7'h19);
    loc_read("R9 local reads zero", 7'h19);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule